// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides where a 32-bit core with fixed four-byte instructions fetches next. Each cycle it takes the current program counter, the raw instruction word, the two source operand values and the three saved return addresses (subroutine return, debug-break return and exception return). From these it produces the following program counter, a flag that is set when control flow leaves the sequential path, a register write request with index and value for instructions that save a return address, and a strobe that tells the core to copy the saved status word back into the live status register.

The unit covers absolute jumps that stay inside the current 256 MiB region, calls, PC-relative unconditional and conditional branches, jumps and calls through a register, the three return forms, and the instruction that reads the address of the next instruction. All other instructions continue to PC+4. Outputs are registered, so results appear one clock after the inputs that produced them.

Top module: `nxpc_unit`

## Requirements
- R1: While `rst_n` is low, every output is zero.
- R2: Opcode 0x01 (instruction bits [5:0]) is an absolute jump. The target is the upper four bits of PC joined with the 26-bit field in bits [31:6], shifted left by two. The taken flag is set.
- R3: Opcode 0x00 is a call. It jumps exactly as R2 does and requests a write of PC+4 to register 31.
- R4: Opcode 0x06 branches unconditionally to PC+4 plus the sign-extended 16-bit field in bits [21:6], with the two low bits of that field cleared.
- R5: Conditional branches compare operand a (field bits [31:27]) with operand b (bits [26:22]). The opcodes are 0x0E signed a>=b, 0x16 signed a<b, 0x1E a!=b, 0x26 a==b, 0x2E unsigned a>=b and 0x36 unsigned a<b. When the condition holds, the target is the R4 target and the taken flag is set. When it fails, the result is PC+4 with the taken flag clear.
- R6: In register format (opcode 0x3A, extended opcode in bits [16:11]), extended code 0x05 goes to the subroutine return address and 0x09 goes to the break return address. Both set the taken flag.
- R7: Extended code 0x01 goes to the exception return address and asserts the status-restore strobe. No other instruction asserts the strobe.
- R8: Extended code 0x0D jumps to operand a. Extended code 0x1D does the same and also requests a write of PC+4 to register 31.
- R9: Extended code 0x1C requests a write of PC+4 to the register named by bits [21:17] and leaves the taken flag clear. When that field is 0, no write is requested.
- R10: Any other instruction gives PC+4 with no taken flag, no write and no strobe. When no write is requested, the write index and value outputs are zero.
- R11: Outputs change only at a rising clock edge and reflect the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| insn_i | input | 32 | Current instruction word |
| opa_i | input | 32 | Value of source operand a |
| opb_i | input | 32 | Value of source operand b |
| ret_sub_i | input | 32 | Saved subroutine return address |
| ret_brk_i | input | 32 | Saved break return address |
| ret_exc_i | input | 32 | Saved exception return address |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Register write request |
| link_idx_o | output | 5 | Register index for the write |
| link_val_o | output | 32 | Value to write (PC+4) |
| status_restore_o | output | 1 | Copy the saved status into the live status |

## Verification
The design holds no state beyond its output register. A wrong decode or a wrong target therefore appears at the ports in the very next cycle, as a wrong `next_pc_o` or flag, and it never hides until a later instruction. The tests target the errors that are hard to see: region bits taken from the wrong side, offsets not masked or not sign-extended, comparisons done with the wrong signedness, a return path swapped for another, and a write to register 0 that is not suppressed. Region and address-wrap boundaries are driven so that an adder or concatenation of the wrong width shows up in the upper bits.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
    localparam int WORD_W = 32;
    localparam int REG_W  = 5;
    localparam int OP_W   = 6;
    localparam int IMM_W  = 16;
    localparam int JIMM_W = WORD_W - OP_W;
    localparam int REGION_W = WORD_W - JIMM_W - 2;
    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    localparam logic [OP_W-1:0] OP_CALL  = 6'h00;
    localparam logic [OP_W-1:0] OP_JABS  = 6'h01;
    localparam logic [OP_W-1:0] OP_BRA   = 6'h06;
    localparam logic [OP_W-1:0] OP_BGE   = 6'h0E;
    localparam logic [OP_W-1:0] OP_BLT   = 6'h16;
    localparam logic [OP_W-1:0] OP_BNE   = 6'h1E;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'h26;
    localparam logic [OP_W-1:0] OP_BGEU  = 6'h2E;
    localparam logic [OP_W-1:0] OP_BLTU  = 6'h36;
    localparam logic [OP_W-1:0] OP_RFMT  = 6'h3A;

    localparam logic [OP_W-1:0] X_RETEXC = 6'h01;
    localparam logic [OP_W-1:0] X_RETSUB = 6'h05;
    localparam logic [OP_W-1:0] X_RETBRK = 6'h09;
    localparam logic [OP_W-1:0] X_JREG   = 6'h0D;
    localparam logic [OP_W-1:0] X_HERE   = 6'h1C;
    localparam logic [OP_W-1:0] X_CREG   = 6'h1D;

    typedef enum logic [3:0] {
        K_SEQ, K_JABS, K_CALL, K_BRA, K_BCOND,
        K_RETSUB, K_RETBRK, K_RETEXC, K_JREG, K_CREG, K_HERE
    } flow_kind_e;

    typedef enum logic [2:0] {
        CMP_GE, CMP_LT, CMP_NE, CMP_EQ, CMP_GEU, CMP_LTU
    } cmp_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] next_pc;
        logic              taken;
        logic              link_we;
        logic [REG_W-1:0]  link_idx;
        logic [WORD_W-1:0] link_val;
        logic              status_restore;
    } flow_out_t;
endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
    import nxpc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [OP_W-1:0] opx_i,
    output flow_kind_e      kind_o,
    output cmp_sel_e        cmp_o
);
    always_comb begin
        kind_o = K_SEQ;
        cmp_o  = CMP_EQ;
        unique case (op_i)
            OP_CALL: kind_o = K_CALL;
            OP_JABS: kind_o = K_JABS;
            OP_BRA:  kind_o = K_BRA;
            OP_BGE:  begin kind_o = K_BCOND; cmp_o = CMP_GE;  end
            OP_BLT:  begin kind_o = K_BCOND; cmp_o = CMP_LT;  end
            OP_BNE:  begin kind_o = K_BCOND; cmp_o = CMP_NE;  end
            OP_BEQ:  begin kind_o = K_BCOND; cmp_o = CMP_EQ;  end
            OP_BGEU: begin kind_o = K_BCOND; cmp_o = CMP_GEU; end
            OP_BLTU: begin kind_o = K_BCOND; cmp_o = CMP_LTU; end
            OP_RFMT: begin
                unique case (opx_i)
                    X_RETEXC: kind_o = K_RETEXC;
                    X_RETSUB: kind_o = K_RETSUB;
                    X_RETBRK: kind_o = K_RETBRK;
                    X_JREG:   kind_o = K_JREG;
                    X_CREG:   kind_o = K_CREG;
                    X_HERE:   kind_o = K_HERE;
                    default:  kind_o = K_SEQ;
                endcase
            end
            default: kind_o = K_SEQ;
        endcase
    end
endmodule

// File: rtl/nxpc_cmp.sv
module nxpc_cmp
    import nxpc_pkg::*;
(
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  cmp_sel_e          sel_i,
    output logic              hit_o
);
    logic eq, lt_s, lt_u;

    always_comb begin
        eq   = (a_i == b_i);
        lt_s = ($signed(a_i) < $signed(b_i));
        lt_u = (a_i < b_i);
        unique case (sel_i)
            CMP_GE:  hit_o = !lt_s;
            CMP_LT:  hit_o = lt_s;
            CMP_NE:  hit_o = !eq;
            CMP_EQ:  hit_o = eq;
            CMP_GEU: hit_o = !lt_u;
            CMP_LTU: hit_o = lt_u;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/nxpc_target.sv
module nxpc_target
    import nxpc_pkg::*;
(
    input  logic [WORD_W-1:0] pc_i,
    input  logic [JIMM_W-1:0] jimm_i,
    output logic [WORD_W-1:0] seq_o,
    output logic [WORD_W-1:0] abs_o,
    output logic [WORD_W-1:0] rel_o
);
    localparam int EXT_W = WORD_W - IMM_W;
    logic [IMM_W-1:0]  off16;
    logic [WORD_W-1:0] off_ext;

    always_comb begin
        off16   = jimm_i[IMM_W-1:0];
        off_ext = {{EXT_W{off16[IMM_W-1]}}, off16[IMM_W-1:2], 2'b00};
        seq_o   = pc_i + WORD_W'(4);
        abs_o   = {pc_i[WORD_W-1 -: REGION_W], jimm_i, 2'b00};
        rel_o   = seq_o + off_ext;
    end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
    import nxpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] insn_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [WORD_W-1:0] ret_sub_i,
    input  logic [WORD_W-1:0] ret_brk_i,
    input  logic [WORD_W-1:0] ret_exc_i,
    output logic [WORD_W-1:0] next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [REG_W-1:0]  link_idx_o,
    output logic [WORD_W-1:0] link_val_o,
    output logic              status_restore_o
);
    localparam int DST_LSB = 2 * OP_W + REG_W;

    flow_kind_e        kind;
    cmp_sel_e          csel;
    logic              cond_hit;
    logic [WORD_W-1:0] t_seq, t_abs, t_rel;
    logic [REG_W-1:0]  dst_c;
    flow_out_t         st_d, st_q;
    logic              live_q;

    assign dst_c = insn_i[DST_LSB +: REG_W];

    nxpc_decode u_dec (
        .op_i   (insn_i[OP_W-1:0]),
        .opx_i  (insn_i[OP_W+REG_W +: OP_W]),
        .kind_o (kind),
        .cmp_o  (csel)
    );

    nxpc_cmp u_cmp (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sel_i (csel),
        .hit_o (cond_hit)
    );

    nxpc_target u_tgt (
        .pc_i   (pc_i),
        .jimm_i (insn_i[WORD_W-1:OP_W]),
        .seq_o  (t_seq),
        .abs_o  (t_abs),
        .rel_o  (t_rel)
    );

    always_comb begin
        st_d         = '0;
        st_d.next_pc = t_seq;
        unique case (kind)
            K_JABS:   begin st_d.next_pc = t_abs; st_d.taken = 1'b1; end
            K_CALL:   begin
                st_d.next_pc  = t_abs;  st_d.taken = 1'b1;
                st_d.link_we  = 1'b1;   st_d.link_idx = LINK_REG;
            end
            K_BRA:    begin st_d.next_pc = t_rel; st_d.taken = 1'b1; end
            K_BCOND:  if (cond_hit) begin
                st_d.next_pc = t_rel; st_d.taken = 1'b1;
            end
            K_RETSUB: begin st_d.next_pc = ret_sub_i; st_d.taken = 1'b1; end
            K_RETBRK: begin st_d.next_pc = ret_brk_i; st_d.taken = 1'b1; end
            K_RETEXC: begin
                st_d.next_pc = ret_exc_i; st_d.taken = 1'b1;
                st_d.status_restore = 1'b1;
            end
            K_JREG:   begin st_d.next_pc = opa_i; st_d.taken = 1'b1; end
            K_CREG:   begin
                st_d.next_pc  = opa_i;  st_d.taken = 1'b1;
                st_d.link_we  = 1'b1;   st_d.link_idx = LINK_REG;
            end
            K_HERE:   if (dst_c != '0) begin
                st_d.link_we  = 1'b1;   st_d.link_idx = dst_c;
            end
            default:  ;
        endcase
        if (st_d.link_we) st_d.link_val = t_seq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            live_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            live_q <= 1'b1;
        end
    end

    assign next_pc_o        = st_q.next_pc;
    assign taken_o          = st_q.taken;
    assign link_we_o        = st_q.link_we;
    assign link_idx_o       = st_q.link_idx;
    assign link_val_o       = st_q.link_val;
    assign status_restore_o = st_q.status_restore;

    // R10, R5: a sequential result is always the previous PC plus four
    assert_seq_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !taken_o) |-> (next_pc_o == $past(pc_i) + 32'd4));

    // R9: no write request ever targets register 0
    assert_no_zero_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (link_idx_o != '0));

    // R3, R8: the saved link value is the address after the instruction
    assert_link_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && link_we_o) |-> (link_val_o == $past(pc_i) + 32'd4));

    // R7: the status restore goes with a taken return to the exception address
    assert_restore_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && status_restore_o) |-> (taken_o && next_pc_o == $past(ret_exc_i)));

    // R7: a status restore never comes with a register write
    assert_restore_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_restore_o, link_we_o}));

    // R1: outputs are cleared in the cycle after reset is sampled
    assert_reset_clear_R1: assert property (@(posedge clk)
        (!$past(rst_n) && !rst_n) |-> (!taken_o && !link_we_o && !status_restore_o
                                       && next_pc_o == '0));
endmodule

// File: tb/tb_nxpc_unit.sv
module tb_nxpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, insn_i = '0, opa_i = '0, opb_i = '0;
    logic [31:0] ret_sub_i = '0, ret_brk_i = '0, ret_exc_i = '0;
    logic [31:0] next_pc_o, link_val_o;
    logic        taken_o, link_we_o, status_restore_o;
    logic [4:0]  link_idx_o;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nxpc_unit dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .insn_i(insn_i),
        .opa_i(opa_i), .opb_i(opb_i), .ret_sub_i(ret_sub_i),
        .ret_brk_i(ret_brk_i), .ret_exc_i(ret_exc_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_idx_o(link_idx_o), .link_val_o(link_val_o),
        .status_restore_o(status_restore_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] a,
                                          input logic [4:0] b, input logic [15:0] imm);
        return {a, b, imm, op};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] imm);
        return {imm, op};
    endfunction
    function automatic logic [31:0] enc_r(input logic [5:0] opx, input logic [4:0] a,
                                          input logic [4:0] c);
        return {a, 5'd3, c, opx, 5'd0, 6'h3A};
    endfunction

    task automatic expect_out(input string tag, input logic [31:0] e_pc, input logic e_tk,
                              input logic e_we, input logic [4:0] e_idx,
                              input logic [31:0] e_val, input logic e_sr);
        n_chk++;
        if (next_pc_o !== e_pc || taken_o !== e_tk || link_we_o !== e_we ||
            link_idx_o !== e_idx || link_val_o !== e_val || status_restore_o !== e_sr) begin
            n_bad++;
            $display("FAIL %s: got pc=%h tk=%b we=%b idx=%0d val=%h sr=%b exp pc=%h tk=%b we=%b idx=%0d val=%h sr=%b",
                     tag, next_pc_o, taken_o, link_we_o, link_idx_o, link_val_o,
                     status_restore_o, e_pc, e_tk, e_we, e_idx, e_val, e_sr);
        end
    endtask

    task automatic apply(input logic [31:0] pc, input logic [31:0] insn,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        pc_i = pc; insn_i = insn; opa_i = a; opb_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        pc_i = 32'h1000; insn_i = enc_j(6'h01, 26'h3FFFFFF);
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 reset", 32'h0, 0, 0, 5'd0, 32'h0, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_jump();
        apply(32'h3FFFFFFC, enc_j(6'h01, 26'h3FFFFFF), 0, 0);
        expect_out("R2 jump region top", 32'h3FFFFFFC, 1, 0, 5'd0, 32'h0, 0);
        apply(32'hA0001000, enc_j(6'h01, 26'h0000010), 0, 0);
        expect_out("R2 jump keeps region", 32'hA0000040, 1, 0, 5'd0, 32'h0, 0);
    endtask

    task automatic t_call();
        apply(32'h7FFFFFFC, enc_j(6'h00, 26'h0000123), 0, 0);
        expect_out("R3 call at region end", 32'h7000048C, 1, 1, 5'd31, 32'h80000000, 0);
    endtask

    task automatic t_bra();
        apply(32'h00001000, enc_i(6'h06, 5'd1, 5'd2, 16'hFFF7), 0, 0);
        expect_out("R4 negative offset masked", 32'h00000FF8, 1, 0, 5'd0, 32'h0, 0);
        apply(32'h00001000, enc_i(6'h06, 5'd1, 5'd2, 16'h0013), 0, 0);
        expect_out("R4 positive offset masked", 32'h00001014, 1, 0, 5'd0, 32'h0, 0);
        apply(32'hFFFFFFF8, enc_i(6'h06, 5'd0, 5'd0, 16'h0008), 0, 0);
        expect_out("R4 wrap", 32'h00000004, 1, 0, 5'd0, 32'h0, 0);
    endtask

    task automatic t_bcond();
        logic [5:0] ops [6] = '{6'h0E, 6'h16, 6'h1E, 6'h26, 6'h2E, 6'h36};
        bit hit_mix [6] = '{0, 1, 1, 0, 1, 0};
        bit hit_eq  [6] = '{1, 0, 0, 1, 1, 0};
        for (int i = 0; i < 6; i++) begin
            apply(32'h00002000, enc_i(ops[i], 5'd4, 5'd5, 16'hFFF0), 32'hFFFFFFFF, 32'h1);
            expect_out($sformatf("R5 op %h a=-1 b=1", ops[i]),
                       hit_mix[i] ? 32'h00001FF4 : 32'h00002004, hit_mix[i], 0, 5'd0, 32'h0, 0);
            apply(32'h00002000, enc_i(ops[i], 5'd4, 5'd5, 16'hFFF0), 32'h80000000, 32'h80000000);
            expect_out($sformatf("R5 op %h equal", ops[i]),
                       hit_eq[i] ? 32'h00001FF4 : 32'h00002004, hit_eq[i], 0, 5'd0, 32'h0, 0);
        end
    endtask

    task automatic t_returns();
        ret_sub_i = 32'h11110000; ret_brk_i = 32'h22220004; ret_exc_i = 32'h33330008;
        apply(32'h400, enc_r(6'h05, 5'd0, 5'd0), 32'h5, 0);
        expect_out("R6 return sub", 32'h11110000, 1, 0, 5'd0, 32'h0, 0);
        apply(32'h400, enc_r(6'h09, 5'd0, 5'd0), 32'h5, 0);
        expect_out("R6 return brk", 32'h22220004, 1, 0, 5'd0, 32'h0, 0);
        apply(32'h400, enc_r(6'h01, 5'd0, 5'd0), 32'h5, 0);
        expect_out("R7 return exc restore", 32'h33330008, 1, 0, 5'd0, 32'h0, 1);
    endtask

    task automatic t_jreg();
        apply(32'h500, enc_r(6'h0D, 5'd9, 5'd0), 32'h44440010, 0);
        expect_out("R8 jump reg", 32'h44440010, 1, 0, 5'd0, 32'h0, 0);
        apply(32'h500, enc_r(6'h1D, 5'd9, 5'd0), 32'h55550020, 0);
        expect_out("R8 call reg", 32'h55550020, 1, 1, 5'd31, 32'h00000504, 0);
    endtask

    task automatic t_here();
        apply(32'h600, enc_r(6'h1C, 5'd0, 5'd7), 0, 0);
        expect_out("R9 next pc to r7", 32'h604, 0, 1, 5'd7, 32'h604, 0);
        apply(32'h600, enc_r(6'h1C, 5'd0, 5'd0), 0, 0);
        expect_out("R9 write to r0 dropped", 32'h604, 0, 0, 5'd0, 32'h0, 0);
    endtask

    task automatic t_other();
        apply(32'h700, enc_i(6'h04, 5'd1, 5'd2, 16'hFFFF), 0, 0);
        expect_out("R10 immediate add", 32'h704, 0, 0, 5'd0, 32'h0, 0);
        apply(32'h700, enc_r(6'h31, 5'd1, 5'd2), 0, 0);
        expect_out("R10 register add", 32'h704, 0, 0, 5'd0, 32'h0, 0);
        apply(32'hFFFFFFFC, enc_r(6'h00, 5'd1, 5'd2), 0, 0);
        expect_out("R10 unused ext code wraps", 32'h0, 0, 0, 5'd0, 32'h0, 0);
    endtask

    task automatic t_latency();
        apply(32'hB0000000, enc_j(6'h01, 26'h0000001), 0, 0);
        #1;
        pc_i = 32'h10; insn_i = enc_i(6'h04, 5'd0, 5'd0, 16'h0);
        #1;
        expect_out("R11 holds until edge", 32'hB0000004, 1, 0, 5'd0, 32'h0, 0);
        @(posedge clk); #1;
        expect_out("R11 updates at edge", 32'h14, 0, 0, 5'd0, 32'h0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_jump();
        t_call();
        t_bra();
        t_bcond();
        t_returns();
        t_jreg();
        t_here();
        t_other();
        t_latency();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule